// File: doc/BRIEF.md
# Dual 8-bit Cascadable Compare Timer

This block holds two 8-bit up-counters, each paced by its own choice of divide ratio from one shared prescaler. Each counter is compared against two programmable constants, A and B. A match can pulse an interrupt, and it can also reset the counter. When a counter rolls over from its top value it pulses an overflow interrupt. Software reaches the block through a byte-addressed register window. Address bit 0 picks the channel. A 16-bit access touches the same register of both channels at once, with channel 0 in the high byte.

The channels can be linked in two ways. In the first, channel 1 counts the compare-A matches of channel 0. In the second, channel 0 selects the chained source and the pair becomes one 16-bit counter with channel 0 as the high byte. That counter uses channel 0's divide ratio, control bits and interrupt outputs, and the compare constants of the two channels are joined into 16-bit values. The external and reserved clock sources do not count.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, each channel reads back as follows: control 0x00, compare A 0xFF, compare B 0xFF, counter 0x00, clock control 0x00. Status reads 0x00 on channel 0 and 0x10 on channel 1. Register index = address bits 3:1: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter, 5 clock control.
- R2: Read masks apply as follows. Control keeps bits 7:3, with clear mode in bits 4:3, overflow enable in bit 5, A enable in bit 6 and B enable in bit 7. Status keeps bits 5:0, and on channel 1 bits 5:4 always read 01. Clock control keeps bits 7 and 4:0, with divide select in bits 2:0 and source in bits 4:3. All other bits read 0.
- R3: Divide select 0 stops the counter. Values 1 to 7 advance it exactly once per 1, 2, 8, 32, 64, 1024 or 8192 clock cycles.
- R4: On an advance while the counter equals A, the A interrupt pulses if its enable is set. With clear mode 1 the counter loads 0 instead of incrementing.
- R5: On an advance while the counter equals B, the B interrupt pulses if its enable is set. With clear mode 2 the counter loads 0 instead of incrementing.
- R6: An advance from the top value (0xFF, or 0xFFFF when chained) that is not a clear wraps the counter to 0 and pulses overflow if that is enabled.
- R7: Source 0 (external) and source 2 (reserved) never change the counter.
- R8: With channel 0 source 3, the pair counts as {ch0, ch1} at channel 0's divide ratio, against {A0, A1} and {B0, B1}, using channel 0's control bits. Channel 1 does not count on its own and raises no interrupts.
- R9: With channel 1 source 3 and channel 0 not chained, channel 1 advances once for every compare-A match event of channel 0, whether or not the A interrupt is enabled.
- R10: A 16-bit access at even offsets 4, 6, 8 or 10 reads and writes channel 0 on bits 15:8 and channel 1 on bits 7:0. A byte read returns the value on bits 7:0 with bits 15:8 at 0. Read data is valid in the same cycle as the address.
- R11: Any other 16-bit access is ignored on write and reads 0xFFFF. Offsets 12 and 14 ignore writes and read 0xFF.
- R12: Each interrupt is registered and goes high for one cycle right after the advancing edge. A counter write in a cycle wins over counting, and that cycle raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 4 | Byte offset; bit 0 selects the channel |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq_cma | output | 2 | Compare-A pulses, one per channel |
| irq_cmb | output | 2 | Compare-B pulses, one per channel |
| irq_ovf | output | 2 | Overflow pulses, one per channel |

## Verification
The bench builds the block with the default prescaler width of 13 bits. At that width the slowest ratio of 8192 fits into a short run, so every divide select is measured over a window of exact multiples of its period. For the random phases the counters run at divide-by-one. This places wraps, clears and chained matches in every few hundred cycles, and the compare constants are picked close to the start values so that matches happen often.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int N_CH   = 2;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {SRC_EXT = 2'd0, SRC_INT = 2'd1, SRC_BAD = 2'd2, SRC_CHAIN = 2'd3} src_e;
  typedef enum logic [2:0] {
    IX_CTL = 3'd0, IX_STS = 3'd1, IX_CMPA = 3'd2, IX_CMPB = 3'd3, IX_CNT = 3'd4, IX_PACE = 3'd5
  } reg_ix_e;

  localparam logic [1:0] CLR_ON_A = 2'd1;
  localparam logic [1:0] CLR_ON_B = 2'd2;

  localparam logic [BYTE_W-1:0] CTL_MASK  = 8'hF8;
  localparam logic [BYTE_W-1:0] STS_MASK  = 8'h3F;
  localparam logic [BYTE_W-1:0] PACE_MASK = 8'h9F;
  localparam logic [BYTE_W-1:0] STS1_RST  = 8'h10;

  typedef struct packed {
    logic [WORD_W-1:0] nxt;
    logic              hit_a;
    logic              hit_b;
    logic              wrap;
  } step_t;

  // Low-bit mask of the shared prescaler that must be all ones for a tick.
  function automatic logic [WORD_W-1:0] div_mask(input logic [2:0] sel);
    case (sel)
      3'd1:    return 16'h0000;
      3'd2:    return 16'h0001;
      3'd3:    return 16'h0007;
      3'd4:    return 16'h001F;
      3'd5:    return 16'h003F;
      3'd6:    return 16'h03FF;
      3'd7:    return 16'h1FFF;
      default: return 16'h0000;
    endcase
  endfunction

  // One advance of a counter: match flags, clear and wrap.
  function automatic step_t count_step(input logic [WORD_W-1:0] cnt,
                                       input logic [WORD_W-1:0] a,
                                       input logic [WORD_W-1:0] b,
                                       input logic [1:0]        clr,
                                       input logic              wide);
    step_t             r;
    logic [WORD_W-1:0] top;
    logic              clear;
    top     = wide ? {WORD_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    r.hit_a = (cnt == a);
    r.hit_b = (cnt == b);
    clear   = (clr == CLR_ON_A && r.hit_a) || (clr == CLR_ON_B && r.hit_b);
    r.wrap  = !clear && (cnt == top);
    r.nxt   = (clear || r.wrap) ? '0 : cnt + 1'b1;
    return r;
  endfunction

  function automatic logic wide_allowed(input logic [3:0] addr);
    return !addr[0] && (addr[3:1] inside {IX_CMPA, IX_CMPB, IX_CNT, IX_PACE});
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRESC_W = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0][2:0]  div_sel,
  output logic [N_CH-1:0]       tick
);
  logic [PRESC_W-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt + 1'b1;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_tick
    logic [PRESC_W-1:0] m;
    assign m       = PRESC_W'(div_mask(div_sel[c]));
    assign tick[c] = (div_sel[c] != 3'd0) && ((pcnt & m) == m);
  end
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_wide,
  input  logic [3:0]                   bus_addr,
  input  logic [WORD_W-1:0]            bus_wdata,
  input  logic [N_CH-1:0][BYTE_W-1:0]  cnt_q,
  output logic [N_CH-1:0][BYTE_W-1:0]  ctl_q,
  output logic [N_CH-1:0][BYTE_W-1:0]  sts_q,
  output logic [N_CH-1:0][BYTE_W-1:0]  cmpa_q,
  output logic [N_CH-1:0][BYTE_W-1:0]  cmpb_q,
  output logic [N_CH-1:0][BYTE_W-1:0]  pace_q,
  output logic [N_CH-1:0]              cnt_wr,
  output logic [N_CH-1:0][BYTE_W-1:0]  cnt_wdata,
  output logic [WORD_W-1:0]            bus_rdata
);
  logic [2:0]                  ix;
  logic                        wide_ok;
  logic [N_CH-1:0][BYTE_W-1:0] rd_byte;

  assign ix      = bus_addr[3:1];
  assign wide_ok = wide_allowed(bus_addr);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic              hit;
    logic [BYTE_W-1:0] wb;
    assign hit = bus_wr && (bus_wide ? wide_ok : (bus_addr[0] == 1'(c)));
    assign wb  = bus_wide ? bus_wdata[WORD_W-1-BYTE_W*c -: BYTE_W] : bus_wdata[BYTE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[c]  <= '0;
        sts_q[c]  <= (c == 1) ? STS1_RST : '0;
        cmpa_q[c] <= '1;
        cmpb_q[c] <= '1;
        pace_q[c] <= '0;
      end else if (hit) begin
        case (ix)
          IX_CTL:  ctl_q[c]  <= wb & CTL_MASK;
          IX_STS:  sts_q[c]  <= wb & STS_MASK;
          IX_CMPA: cmpa_q[c] <= wb;
          IX_CMPB: cmpb_q[c] <= wb;
          IX_PACE: pace_q[c] <= wb & PACE_MASK;
          default: ;
        endcase
      end
    end

    assign cnt_wr[c]    = hit && (ix == IX_CNT);
    assign cnt_wdata[c] = wb;

    always_comb begin
      case (ix)
        IX_CTL:  rd_byte[c] = ctl_q[c];
        IX_STS:  rd_byte[c] = (c == 1) ? ((sts_q[c] & 8'h0F) | STS1_RST) : sts_q[c];
        IX_CMPA: rd_byte[c] = cmpa_q[c];
        IX_CMPB: rd_byte[c] = cmpb_q[c];
        IX_CNT:  rd_byte[c] = cnt_q[c];
        IX_PACE: rd_byte[c] = pace_q[c];
        default: rd_byte[c] = '1;
      endcase
    end
  end

  always_comb begin
    if (bus_wide) bus_rdata = wide_ok ? {rd_byte[0], rd_byte[1]} : '1;
    else          bus_rdata = {{BYTE_W{1'b0}}, rd_byte[bus_addr[0]]};
  end
endmodule

// File: rtl/tmr_counter_core.sv
module tmr_counter_core
  import tmr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_CH-1:0][BYTE_W-1:0]  ctl_q,
  input  logic [N_CH-1:0][BYTE_W-1:0]  cmpa_q,
  input  logic [N_CH-1:0][BYTE_W-1:0]  cmpb_q,
  input  logic [N_CH-1:0][BYTE_W-1:0]  pace_q,
  input  logic [N_CH-1:0]              ptick,
  input  logic [N_CH-1:0]              cnt_wr,
  input  logic [N_CH-1:0][BYTE_W-1:0]  cnt_wdata,
  output logic [N_CH-1:0][BYTE_W-1:0]  cnt_q,
  output logic                         chained16,
  output logic                         evt_a0,
  output logic [N_CH-1:0]              irq_cma,
  output logic [N_CH-1:0]              irq_cmb,
  output logic [N_CH-1:0]              irq_ovf
);
  src_e  src0, src1;
  logic  tick0, tick1, adv16, adv0, adv1;
  step_t s16, s0, s1;

  assign src0      = src_e'(pace_q[0][4:3]);
  assign src1      = src_e'(pace_q[1][4:3]);
  assign chained16 = (src0 == SRC_CHAIN);

  assign s16 = count_step({cnt_q[0], cnt_q[1]}, {cmpa_q[0], cmpa_q[1]},
                          {cmpb_q[0], cmpb_q[1]}, ctl_q[0][4:3], 1'b1);
  assign s0  = count_step({8'h00, cnt_q[0]}, {8'h00, cmpa_q[0]},
                          {8'h00, cmpb_q[0]}, ctl_q[0][4:3], 1'b0);
  assign s1  = count_step({8'h00, cnt_q[1]}, {8'h00, cmpa_q[1]},
                          {8'h00, cmpb_q[1]}, ctl_q[1][4:3], 1'b0);

  assign tick0  = ptick[0] && (src0 == SRC_INT || chained16);
  assign adv16  = chained16 && tick0 && !(|cnt_wr);
  assign adv0   = !chained16 && tick0 && !cnt_wr[0];
  assign evt_a0 = adv0 && s0.hit_a;

  always_comb begin
    tick1 = 1'b0;
    if (!chained16) begin
      if (src1 == SRC_INT)        tick1 = ptick[1];
      else if (src1 == SRC_CHAIN) tick1 = evt_a0;
    end
  end
  assign adv1 = tick1 && !cnt_wr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      if (adv16) begin
        cnt_q[0] <= s16.nxt[WORD_W-1:BYTE_W];
        cnt_q[1] <= s16.nxt[BYTE_W-1:0];
      end else begin
        if (cnt_wr[0])  cnt_q[0] <= cnt_wdata[0];
        else if (adv0)  cnt_q[0] <= s0.nxt[BYTE_W-1:0];
        if (cnt_wr[1])  cnt_q[1] <= cnt_wdata[1];
        else if (adv1)  cnt_q[1] <= s1.nxt[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_cma <= '0;
      irq_cmb <= '0;
      irq_ovf <= '0;
    end else begin
      irq_cma[0] <= ((adv16 && s16.hit_a) || (adv0 && s0.hit_a)) && ctl_q[0][6];
      irq_cmb[0] <= ((adv16 && s16.hit_b) || (adv0 && s0.hit_b)) && ctl_q[0][7];
      irq_ovf[0] <= ((adv16 && s16.wrap)  || (adv0 && s0.wrap))  && ctl_q[0][5];
      irq_cma[1] <= adv1 && s1.hit_a && ctl_q[1][6];
      irq_cmb[1] <= adv1 && s1.hit_b && ctl_q[1][7];
      irq_ovf[1] <= adv1 && s1.wrap  && ctl_q[1][5];
    end
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int PRESC_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_wide,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [1:0]  irq_cma,
  output logic [1:0]  irq_cmb,
  output logic [1:0]  irq_ovf
);
  logic [N_CH-1:0][BYTE_W-1:0] ctl_q, sts_q, cmpa_q, cmpb_q, pace_q, cnt_q, cnt_wdata;
  logic [N_CH-1:0]             cnt_wr, ptick;
  logic [N_CH-1:0][2:0]        div_sel;
  logic                        chained16, evt_a0;

  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    assign div_sel[c] = pace_q[c][2:0];
  end

  tmr_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q),
    .ctl_q(ctl_q), .sts_q(sts_q), .cmpa_q(cmpa_q), .cmpb_q(cmpb_q),
    .pace_q(pace_q), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .bus_rdata(bus_rdata)
  );

  tmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(ptick)
  );

  tmr_counter_core u_core (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .cmpa_q(cmpa_q), .cmpb_q(cmpb_q),
    .pace_q(pace_q), .ptick(ptick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_q(cnt_q), .chained16(chained16), .evt_a0(evt_a0),
    .irq_cma(irq_cma), .irq_cmb(irq_cmb), .irq_ovf(irq_ovf)
  );
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0][7:0] ctl_q,
  input logic [1:0][7:0] pace_q,
  input logic [1:0][7:0] cnt_q,
  input logic [1:0]      cnt_wr,
  input logic            evt_a0,
  input logic [1:0]      irq_cma,
  input logic [1:0]      irq_cmb,
  input logic [1:0]      irq_ovf
);
  // R3: divide select 0 on an internal source holds the counter
  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_q[0][4:3] == 2'd1 && pace_q[0][2:0] == 3'd0 && !cnt_wr[0]) |=> $stable(cnt_q[0]));

  // R7: external and reserved sources never count
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((pace_q[0][4:3] == 2'd0 || pace_q[0][4:3] == 2'd2) && !cnt_wr[0]) |=> $stable(cnt_q[0]));

  // R9: a chained channel 1 moves only on a channel-0 A event
  a_r9_chain_source: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_q[0][4:3] != 2'd3 && pace_q[1][4:3] == 2'd3 && !cnt_wr[1] && !evt_a0)
      |=> $stable(cnt_q[1]));

  // R8: in 16-bit mode channel 1 stays quiet
  a_r8_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_q[0][4:3] == 2'd3) |=> (irq_cma[1] == 1'b0 && irq_cmb[1] == 1'b0 && irq_ovf[1] == 1'b0));

  for (genvar c = 0; c < 2; c++) begin : g_irq
    // R6: an overflow pulse leaves the counter at zero
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf[c] |-> (cnt_q[c] == 8'h00));
    // R12: pulses require their enable one cycle earlier
    a_r12_ovf_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf[c] |-> $past(ctl_q[c][5]));
    // R4: compare-A pulse requires its enable
    a_r4_cma_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cma[c] |-> $past(ctl_q[c][6]));
    // R5: compare-B pulse requires its enable
    a_r5_cmb_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cmb[c] |-> $past(ctl_q[c][7]));
  end
endmodule

bind dual_cmp_timer dual_cmp_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .pace_q(pace_q), .cnt_q(cnt_q),
  .cnt_wr(cnt_wr), .evt_a0(evt_a0), .irq_cma(irq_cma), .irq_cmb(irq_cmb), .irq_ovf(irq_ovf)
);

// File: tb/sim_dual_cmp_timer.sv
`timescale 1ns/1ps
module sim_dual_cmp_timer;
  localparam time HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_wide = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq_cma, irq_cmb, irq_ovf;

  int checks = 0;
  int errors = 0;

  // bench model state
  int m0, m1, ma[2], mb[2], mclr[2], msrc[2];
  logic [7:0] mctl[2];
  logic [5:0] mirq;

  always #HALF clk = ~clk;

  dual_cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cma(irq_cma), .irq_cmb(irq_cmb), .irq_ovf(irq_ovf)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wide = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wide = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic w, output logic [15:0] d);
    bus_addr = a; bus_wide = w;
    #1;
    d = bus_rdata;
  endtask

  // one advance of a modelled counter with the given modulus
  task automatic adv(inout int v, input int a, input int b, input int clr, input int modulus,
                     output logic ha, output logic hb, output logic ho);
    logic zap;
    ha  = (v == a);
    hb  = (v == b);
    zap = (clr == 1 && ha) || (clr == 2 && hb);
    ho  = !zap && (v == modulus - 1);
    v   = zap ? 0 : (v + 1) % modulus;
  endtask

  // model of one clock edge at divide-by-one
  task automatic model_edge();
    logic ha, hb, ho, ev;
    int v;
    mirq = '0;
    ev = 1'b0;
    if (msrc[0] == 3) begin
      v = m0 * 256 + m1;
      adv(v, ma[0] * 256 + ma[1], mb[0] * 256 + mb[1], mclr[0], 65536, ha, hb, ho);
      m0 = v / 256; m1 = v % 256;
      mirq[0] = ha & mctl[0][6]; mirq[2] = hb & mctl[0][7]; mirq[4] = ho & mctl[0][5];
    end else begin
      if (msrc[0] == 1) begin
        adv(m0, ma[0], mb[0], mclr[0], 256, ha, hb, ho);
        ev = ha;
        mirq[0] = ha & mctl[0][6]; mirq[2] = hb & mctl[0][7]; mirq[4] = ho & mctl[0][5];
      end
      if (msrc[1] == 1 || (msrc[1] == 3 && ev)) begin
        adv(m1, ma[1], mb[1], mclr[1], 256, ha, hb, ho);
        mirq[1] = ha & mctl[1][6]; mirq[3] = hb & mctl[1][7]; mirq[5] = ho & mctl[1][5];
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    int shifts[8];
    void'($urandom(32'd4711));
    shifts = '{0, 0, 1, 3, 5, 6, 10, 13};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1: reset state, counters idle on the external source
    for (int c = 0; c < 2; c++) begin
      rd(4'(0 + c), 1'b0, d);  chk("R1 control", d, 16'h0000);
      rd(4'(2 + c), 1'b0, d);  chk("R1 status", d, c == 1 ? 16'h0010 : 16'h0000);
      rd(4'(4 + c), 1'b0, d);  chk("R1 compare A", d, 16'h00FF);
      rd(4'(6 + c), 1'b0, d);  chk("R1 compare B", d, 16'h00FF);
      rd(4'(8 + c), 1'b0, d);  chk("R1 counter", d, 16'h0000);
      rd(4'(10 + c), 1'b0, d); chk("R1 clock control", d, 16'h0000);
    end

    // R2: read masks and forced status field
    wr(4'd0, 1'b0, 16'h00FF); rd(4'd0, 1'b0, d); chk("R2 control mask", d, 16'h00F8);
    wr(4'd2, 1'b0, 16'h00FF); rd(4'd2, 1'b0, d); chk("R2 status ch0", d, 16'h003F);
    wr(4'd3, 1'b0, 16'h002F); rd(4'd3, 1'b0, d); chk("R2 status ch1 field", d, 16'h001F);
    wr(4'd11, 1'b0, 16'h00FF); rd(4'd11, 1'b0, d); chk("R2 clock mask", d, 16'h009F);
    wr(4'd0, 1'b0, 16'h0000); wr(4'd11, 1'b0, 16'h0000);

    // R10: wide accesses map high byte to channel 0
    wr(4'd4, 1'b1, 16'h1234);
    rd(4'd4, 1'b0, d); chk("R10 A ch0", d, 16'h0012);
    rd(4'd5, 1'b0, d); chk("R10 A ch1", d, 16'h0034);
    rd(4'd4, 1'b1, d); chk("R10 A wide", d, 16'h1234);
    wr(4'd8, 1'b1, 16'hABCD);
    rd(4'd8, 1'b0, d); chk("R10 counter ch0", d, 16'h00AB);
    rd(4'd9, 1'b0, d); chk("R10 counter ch1", d, 16'h00CD);

    // R11: illegal wide accesses and unmapped offsets
    wr(4'd0, 1'b1, 16'hFFFF); rd(4'd0, 1'b0, d); chk("R11 wide control write ignored", d, 16'h0000);
    rd(4'd0, 1'b1, d); chk("R11 wide control read", d, 16'hFFFF);
    wr(4'd5, 1'b1, 16'hAAAA); rd(4'd5, 1'b0, d); chk("R11 odd wide write ignored", d, 16'h0034);
    rd(4'd5, 1'b1, d); chk("R11 odd wide read", d, 16'hFFFF);
    wr(4'd12, 1'b0, 16'h0055); rd(4'd12, 1'b0, d); chk("R11 unmapped read", d, 16'h00FF);

    // R7: external and reserved sources hold the counters
    wr(4'd10, 1'b1, 16'h0111);
    repeat (40) @(negedge clk);
    rd(4'd8, 1'b1, d); chk("R7 sources 0 and 2 hold", d, 16'hABCD);

    // R3: every divide select over an exact window
    wr(4'd4, 1'b1, 16'hFFFF); wr(4'd6, 1'b1, 16'hFFFF);
    for (int s = 0; s < 8; s++) begin
      int win;
      win = (s == 0) ? 64 : (4 << shifts[s]);
      wr(4'd10, 1'b1, {8'(8'h08 | s), 8'(8'h08 | s)});
      wr(4'd8, 1'b1, 16'h0000);
      repeat (win) @(negedge clk);
      rd(4'd8, 1'b1, d);
      chk($sformatf("R3 divide select %0d", s), d, (s == 0) ? 16'h0000 : 16'h0404);
    end

    // R12: a counter write wins over counting
    wr(4'd10, 1'b1, 16'h0909);
    wr(4'd8, 1'b0, 16'h0040);
    rd(4'd8, 1'b0, d); chk("R12 write wins", d, 16'h0040);
    @(negedge clk);
    rd(4'd8, 1'b0, d); chk("R12 counting resumes", d, 16'h0041);

    // R4 R5 R6 R8 R9 R12: random runs against the bench model
    for (int it = 0; it < 48; it++) begin
      int mode, s0, s1, st;
      string tag;
      mode = it % 3;
      wr(4'd10, 1'b1, 16'h0000);
      for (int c = 0; c < 2; c++) begin
        mctl[c] = 8'($urandom()) & 8'hF8;
        mclr[c] = int'(mctl[c][4:3]);
      end
      if (mode == 1 && (it % 2 == 0)) begin mctl[0][4:3] = 2'd1; mclr[0] = 1; end
      if (mode == 2) begin
        st = (it % 4 == 0) ? 65535 - int'($urandom() % 60) : int'($urandom() % 65536);
        s0 = (st + int'($urandom() % 120)) % 65536;
        s1 = (st + int'($urandom() % 120)) % 65536;
        ma[0] = s0 / 256; ma[1] = s0 % 256; mb[0] = s1 / 256; mb[1] = s1 % 256;
        m0 = st / 256; m1 = st % 256;
        msrc[0] = 3; msrc[1] = int'($urandom() % 4);
        tag = "R8 R4 R5 R6 R12";
      end else begin
        for (int c = 0; c < 2; c++) begin
          ma[c] = int'($urandom() % 64);
          mb[c] = int'($urandom() % 64);
        end
        if (mode == 1) ma[0] = int'($urandom() % 6);
        m0 = (it % 4 == 1) ? 200 + int'($urandom() % 50) : int'($urandom() % 40);
        m1 = (it % 5 == 0) ? 250 : int'($urandom() % 40);
        msrc[0] = 1; msrc[1] = (mode == 1) ? 3 : 1;
        tag = (mode == 1) ? "R9 R4 R5 R12" : "R4 R5 R6 R12";
      end
      wr(4'd0, 1'b0, {8'h00, mctl[0]});
      wr(4'd1, 1'b0, {8'h00, mctl[1]});
      wr(4'd4, 1'b1, {8'(ma[0]), 8'(ma[1])});
      wr(4'd6, 1'b1, {8'(mb[0]), 8'(mb[1])});
      wr(4'd8, 1'b1, {8'(m0), 8'(m1)});
      wr(4'd10, 1'b1, {8'(msrc[0] * 8 + 1) | (8'($urandom()) & 8'h80), 8'(msrc[1] * 8 + 1)});
      mirq = '0;
      bus_addr = 4'd8; bus_wide = 1'b1;
      for (int n = 0; n < 160; n++) begin
        #1;
        chk({tag, " counters"}, bus_rdata, {8'(m0), 8'(m1)});
        chk({tag, " pulses"}, {10'h000, irq_ovf, irq_cmb, irq_cma}, {10'h000, mirq});
        model_edge();
        @(negedge clk);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule